// File: doc/BRIEF.md
# Socket Buffer FIFO-Window Controller

This block holds a shared packet buffer of sixteen equal blocks. A 16-bit type mask gives each block to the transmit side or to the receive side. The buffer is then divided among eight sockets, each of which gets a transmit region and a receive region. The host cannot address the buffer. It reaches a region only through that socket's FIFO window register. An access pointer moves forward one 16-bit word per access and returns to the region base when it reaches the region end. The host programs each region size in kilobytes. A size must be a multiple of 8, so one size unit is one 8 KB block.

In normal operation the transmit window takes host writes only and the receive window takes host reads only. When the test bit is set in the mode register, transmit reads and receive writes are also allowed. Writes and reads keep separate pointers, so a block of data written into a region can be read back in the same order. A soft-reset bit returns all registers to their defaults. Each socket has a command register that takes OPEN or CLOSE. The command register clears itself and the socket status then shows the new state. The parameter `BLK_WORDS` sets the number of words per block and can be made small for simulation.

Top module: `sockbuf_window`

## Requirements
- R1: After reset the mode register (address 0x00) reads 0x0000 and the type mask (0x01) reads 0x00FF. Every transmit size (0x02+n) and receive size (0x0A+n) reads 8, and every socket status (0x21+4n) reads 0x00 (closed).
- R2: The size, mask and mode registers read back the last value written. A register read returns its data one cycle after `rd`.
- R3: In test mode (mode bit 5), reads of the transmit window (0x22+4n) return the words written there since the last open, in the order they were written.
- R4: Each window pointer advances by one word per allowed access and returns to the region base after the last word of the region. Writing region size + 1 words therefore overwrites word 0, and a following read returns that last word.
- R5: In normal mode a transmit-window read returns 0 and does not move the pointer. A receive-window write stores nothing and does not move the pointer.
- R6: In test mode, writes to the receive window (0x23+4n) are stored in order, and later reads of that window return them in the same order.
- R7: Writing 0x01 (OPEN) to a command register (0x20+4n) puts the socket in status 0x13 (INIT) one cycle later and resets all four of its pointers to the region base. The command register then reads 0.
- R8: Writing 0x10 (CLOSE) to a command register puts the socket in status 0x00 one cycle later.
- R9: OPEN is ignored, and the status stays unchanged, unless all of the following hold: every size is a multiple of 8, the sum of all sizes is 128, and the transmit sum equals 8 times the number of set bits in the type mask.
- R10: An access to a window whose region size is 0 is ignored, returns 0 and leaves the memory of every other region unchanged.
- R11: Writing the mode register with bit 7 set restores every register, status and pointer to its reset value. Bit 7 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Register address |
| wr | input | 1 | Write strobe for one cycle |
| rd | input | 1 | Read strobe for one cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered, valid the cycle after `rd` |

## Verification
A read returns its data in the cycle that follows `rd`, so the bench drives inputs on the falling edge and samples `rdata` on the next falling edge. A command written in one cycle finishes at the next rising edge. The status register is therefore read only after one idle cycle, because a read issued in the cycle right after the write would capture the old value. Window checks depend on the pointer order, so each sequence begins with an OPEN followed by an idle cycle. This puts every pointer at the region base before data is written and compared.

// File: rtl/sockbuf_window.sv
module sockbuf_window #(
  parameter int BLK_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  addr,
  input  logic        wr,
  input  logic        rd,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int BWL  = $clog2(BLK_WORDS);
  localparam int MEMW = 16 * BLK_WORDS;
  localparam int PW   = BWL + 5;
  localparam int LGW  = BWL + 11;
  localparam logic [7:0] CMD_OPEN = 8'h01, CMD_CLOSE = 8'h10;
  localparam logic [7:0] ST_INIT = 8'h13, ST_CLOSED = 8'h00;

  logic [15:0] mem [MEMW];
  logic        test;
  logic [15:0] mask;
  logic [7:0]  tsz [8], rsz [8], cmd [8], stat [8];
  logic [PW-1:0] txw [8], txr [8], rxw [8], rxr [8];
  logic [9:0]  tbase [8], rbase [8];
  logic [9:0]  ttot, rtot;
  logic        cfg_ok, sz_ok;

  function automatic logic [3:0] kth(input logic [15:0] m, input logic [4:0] k);
    logic [4:0] cnt;
    logic       found;
    kth = 4'd0; cnt = 5'd0; found = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (m[i] && !found) begin
        if (cnt == k) begin kth = 4'(i); found = 1'b1; end
        cnt = cnt + 5'd1;
      end
    end
  endfunction

  always_comb begin
    ttot = '0; rtot = '0; sz_ok = 1'b1;
    for (int s = 0; s < 8; s++) begin
      tbase[s] = ttot;
      rbase[s] = rtot;
      ttot = ttot + {5'b0, tsz[s][7:3]};
      rtot = rtot + {5'b0, rsz[s][7:3]};
      if (tsz[s][2:0] != 3'd0 || rsz[s][2:0] != 3'd0) sz_ok = 1'b0;
    end
    cfg_ok = sz_ok && (ttot + rtot == 10'd16) && (ttot == 10'($countones(mask)));
  end

  wire        srst = wr && addr == 6'h00 && wdata[7];
  wire [2:0]  sock = addr[4:2];
  wire        fifo = addr[5] && addr[1];
  wire        istx = !addr[0];
  wire [4:0]  units = istx ? tsz[sock][7:3] : rsz[sock][7:3];
  wire [PW:0] len = {1'b0, units, {BWL{1'b0}}};
  wire [PW-1:0] ptr = istx ? (wr ? txw[sock] : txr[sock]) : (wr ? rxw[sock] : rxr[sock]);
  wire [PW-1:0] nptr = ({1'b0, ptr} + 1'b1 == len) ? '0 : ptr + 1'b1;
  wire        allow = fifo && units != 5'd0 && (istx ? (wr || (rd && test)) : (rd || (wr && test)));
  wire [LGW-1:0] logical = ({{(LGW-10){1'b0}}, istx ? tbase[sock] : rbase[sock]} << BWL)
                           + {{(LGW-PW){1'b0}}, ptr};
  wire [4:0]  lunit = logical[BWL+4:BWL];
  wire [3:0]  pblk = kth(istx ? mask : ~mask, lunit);
  wire [BWL+3:0] phys = {pblk, logical[BWL-1:0]};
  wire [5:0]  am2 = addr - 6'd2;
  wire [5:0]  am10 = addr - 6'd10;

  always_ff @(posedge clk)
    if (allow && wr) mem[phys] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      test <= 1'b0;
      mask <= 16'h00FF;
      for (int s = 0; s < 8; s++) begin
        tsz[s] <= 8'd8; rsz[s] <= 8'd8; cmd[s] <= '0; stat[s] <= ST_CLOSED;
        txw[s] <= '0; txr[s] <= '0; rxw[s] <= '0; rxr[s] <= '0;
      end
    end else begin
      for (int s = 0; s < 8; s++) begin
        if (cmd[s] != 8'd0) begin
          cmd[s] <= '0;
          if (cmd[s] == CMD_OPEN) begin
            stat[s] <= ST_INIT;
            txw[s] <= '0; txr[s] <= '0; rxw[s] <= '0; rxr[s] <= '0;
          end else stat[s] <= ST_CLOSED;
        end
      end
      if (wr) begin
        if (addr == 6'h00) test <= wdata[5];
        if (addr == 6'h01) mask <= wdata;
        if (addr >= 6'h02 && addr <= 6'h09) begin
          tsz[am2[2:0]] <= wdata[7:0]; txw[am2[2:0]] <= '0; txr[am2[2:0]] <= '0;
        end
        if (addr >= 6'h0A && addr <= 6'h11) begin
          rsz[am10[2:0]] <= wdata[7:0]; rxw[am10[2:0]] <= '0; rxr[am10[2:0]] <= '0;
        end
        if (addr[5] && addr[1:0] == 2'b00 && cmd[sock] == 8'd0 &&
            ((wdata == 16'(CMD_OPEN) && cfg_ok) || wdata == 16'(CMD_CLOSE)))
          cmd[sock] <= wdata[7:0];
      end
      if (allow) begin
        if (istx) begin
          if (wr) txw[sock] <= nptr; else txr[sock] <= nptr;
        end else begin
          if (wr) rxw[sock] <= nptr; else rxr[sock] <= nptr;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd) begin
      if (addr == 6'h00) rdata <= {10'b0, test, 5'b0};
      else if (addr == 6'h01) rdata <= mask;
      else if (addr >= 6'h02 && addr <= 6'h09) rdata <= {8'b0, tsz[am2[2:0]]};
      else if (addr >= 6'h0A && addr <= 6'h11) rdata <= {8'b0, rsz[am10[2:0]]};
      else if (fifo) rdata <= allow ? mem[phys] : 16'h0000;
      else if (addr[5] && addr[1:0] == 2'b00) rdata <= {8'b0, cmd[sock]};
      else if (addr[5] && addr[1:0] == 2'b01) rdata <= {8'b0, stat[sock]};
      else rdata <= '0;
    end
  end

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!test && mask == 16'h00FF && stat[1] == ST_CLOSED && tsz[0] == 8'd8));
  assert_tx_read_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && fifo && istx && !test) |=> rdata == 16'h0000);
  assert_empty_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && fifo && units == 5'd0) |=> rdata == 16'h0000);

  for (genvar g = 0; g < 8; g++) begin : g_chk
    assert_cmd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[g] != 8'd0 |=> cmd[g] == 8'd0);
    assert_open_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd[g] == CMD_OPEN && !srst) |=> stat[g] == ST_INIT);
    assert_close_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd[g] == CMD_CLOSE && !srst) |=> stat[g] == ST_CLOSED);
    assert_tx_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tsz[g][7:3] == 5'd0 || (txw[g] < {tsz[g][7:3], {BWL{1'b0}}} && txr[g] < {tsz[g][7:3], {BWL{1'b0}}}));
    assert_rx_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsz[g][7:3] == 5'd0 || (rxw[g] < {rsz[g][7:3], {BWL{1'b0}}} && rxr[g] < {rsz[g][7:3], {BWL{1'b0}}}));
  end
endmodule

// File: tb/sockbuf_window_tb.sv
module sockbuf_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  sockbuf_window u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
                        .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  // op: 0 idle, 1 write, 2 read-and-compare ; fields {op, addr, wdata, expected, req}
  localparam int NV = 30;
  localparam logic [43:0] VEC [NV] = '{
    {2'd2, 6'h00, 16'h0000, 16'h0000, 4'd1},  // R1 mode
    {2'd2, 6'h01, 16'h0000, 16'h00FF, 4'd1},  // R1 mask
    {2'd2, 6'h02, 16'h0000, 16'h0008, 4'd1},  // R1 tx size 0
    {2'd2, 6'h11, 16'h0000, 16'h0008, 4'd1},  // R1 rx size 7
    {2'd2, 6'h21, 16'h0000, 16'h0000, 4'd1},  // R1 status 0
    {2'd1, 6'h05, 16'h0010, 16'h0000, 4'd2},  // R2
    {2'd2, 6'h05, 16'h0000, 16'h0010, 4'd2},
    {2'd1, 6'h05, 16'h0008, 16'h0000, 4'd2},
    {2'd2, 6'h05, 16'h0000, 16'h0008, 4'd2},
    {2'd1, 6'h24, 16'h0001, 16'h0000, 4'd7},  // R7 open socket 1
    {2'd0, 6'h00, 16'h0000, 16'h0000, 4'd7},
    {2'd2, 6'h25, 16'h0000, 16'h0013, 4'd7},
    {2'd1, 6'h26, 16'h1111, 16'h0000, 4'd5},  // R5 normal tx writes
    {2'd1, 6'h26, 16'h2222, 16'h0000, 4'd5},
    {2'd2, 6'h26, 16'h0000, 16'h0000, 4'd5},  // R5 tx read blocked
    {2'd1, 6'h00, 16'h0020, 16'h0000, 4'd2},
    {2'd2, 6'h00, 16'h0000, 16'h0020, 4'd2},
    {2'd2, 6'h26, 16'h0000, 16'h1111, 4'd3},  // R3
    {2'd2, 6'h26, 16'h0000, 16'h2222, 4'd3},
    {2'd1, 6'h27, 16'hAAAA, 16'h0000, 4'd6},  // R6
    {2'd1, 6'h27, 16'hBBBB, 16'h0000, 4'd6},
    {2'd2, 6'h27, 16'h0000, 16'hAAAA, 4'd6},
    {2'd2, 6'h27, 16'h0000, 16'hBBBB, 4'd6},
    {2'd1, 6'h24, 16'h0010, 16'h0000, 4'd8},  // R8 close
    {2'd0, 6'h00, 16'h0000, 16'h0000, 4'd8},
    {2'd2, 6'h25, 16'h0000, 16'h0000, 4'd8},
    {2'd2, 6'h24, 16'h0000, 16'h0000, 4'd7},  // R7 command cleared
    {2'd1, 6'h00, 16'h0000, 16'h0000, 4'd2},
    {2'd2, 6'h00, 16'h0000, 16'h0000, 4'd2},
    {2'd0, 6'h00, 16'h0000, 16'h0000, 4'd1}
  };

  task automatic wreg(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rchk(input logic [5:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    nchk++;
    if (rdata !== e) begin
      nfail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][43:42])
        2'd1: wreg(VEC[i][41:36], VEC[i][35:20]);
        2'd2: rchk(VEC[i][41:36], VEC[i][19:4], $sformatf("R%0d", VEC[i][3:0]));
        default: idle();
      endcase
    end

    // R5: normal-mode receive write is dropped
    wreg(6'h00, 16'h0020); wreg(6'h28, 16'h0001); idle();
    wreg(6'h2B, 16'h1234);
    wreg(6'h00, 16'h0000); wreg(6'h28, 16'h0001); idle();
    wreg(6'h2B, 16'h5555);
    rchk(6'h2B, 16'h1234, "R5");

    // R4: wrap after 32 words of socket 3 transmit region
    wreg(6'h00, 16'h0020); wreg(6'h2C, 16'h0001); idle();
    for (int i = 0; i < 33; i++) wreg(6'h2E, 16'(i * 3 + 1));
    rchk(6'h2E, 16'd97, "R4");
    rchk(6'h2E, 16'd4, "R4");

    // R9: invalid configurations refuse OPEN
    wreg(6'h01, 16'h0FFF); wreg(6'h30, 16'h0001); idle();
    rchk(6'h31, 16'h0000, "R9");
    wreg(6'h01, 16'h00FF); wreg(6'h02, 16'h000C); wreg(6'h30, 16'h0001); idle();
    rchk(6'h31, 16'h0000, "R9");
    wreg(6'h02, 16'h0008); wreg(6'h30, 16'h0001); idle();
    rchk(6'h31, 16'h0013, "R9");

    // R10: zero-sized region of socket 5, neighbour socket 6 intact
    wreg(6'h07, 16'h0000); wreg(6'h08, 16'h0010);
    wreg(6'h38, 16'h0001); idle();
    wreg(6'h3A, 16'h6666);
    wreg(6'h36, 16'h7777);
    rchk(6'h36, 16'h0000, "R10");
    rchk(6'h3A, 16'h6666, "R10");

    // R11: soft reset
    wreg(6'h00, 16'h00A0);
    rchk(6'h00, 16'h0000, "R11");
    rchk(6'h01, 16'h00FF, "R11");
    rchk(6'h07, 16'h0008, "R11");
    rchk(6'h08, 16'h0008, "R11");
    rchk(6'h39, 16'h0000, "R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule